// File: doc/BRIEF.md
# Two-Word Mailbox Queue with Interrupt Flag

This block is a first-in first-out message queue whose entries are 64 bits wide, reached through a simple register port that moves 32 bits per access. A producer builds each message in two writes. The first write goes to the low-half address and is parked in a holding register. The second write goes to the high-half address, four bytes above, and commits `{high, held low}` to the queue as one entry.

A consumer reads the low half of the oldest entry from the low address without consuming it. It then reads the high half from the high address, and that read removes the entry. A level output that is high while any entry is stored is meant to drive an interrupt line. A live full output shows that no further entry can be accepted. A sticky copy of the full condition records that the queue filled at some point. It stays set after the queue drains and clears only on reset or on a clear strobe.

Depth is a parameter and must be a power of two, at least 2. Occupancy is tracked with read and write pointers one bit wider than the slot index. Everything runs on one clock with an active-low synchronous reset.

Top module: `mbox_fifo64`

## Requirements
- R1: After reset the queue is empty: `mb_pending`, `mb_full` and `mb_full_seen` are all 0.
- R2: A write to `LO_ADDR` only loads the holding register. It adds no entry, so `mb_pending` does not change.
- R3: A write to `LO_ADDR + 4` while not full appends `{wdata, holding}` as one entry (high half in bits 63:32). `mb_pending` is 1 from the following cycle.
- R4: A read at `LO_ADDR` returns bits 31:0 of the oldest entry on `rdata` in the same cycle, and does not remove it.
- R5: A read at `LO_ADDR + 4` returns bits 63:32 of the oldest entry in the same cycle, and removes that entry at the clock edge.
- R6: Entries leave in the order they were committed.
- R7: `mb_full` is 1 once `DEPTH` entries are stored. A high-half write while full is dropped, and the stored entries are unchanged.
- R8: `mb_full_seen` is 1 whenever `mb_full` is 1 and stays 1 after the queue drains. A `full_seen_clr` pulse clears it only while the queue is not full.
- R9: A read of either half while empty returns 0 and changes nothing.
- R10: A write to any other address is ignored, including by the holding register. A read of any other address returns 0. With `rd_en` low, `rdata` is 0.
- R11: The holding register keeps its value after a commit, so repeated high-half writes reuse the last low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe (the high-half read removes the head entry) |
| rdata | output | 32 | Read data, valid in the cycle of `rd_en` |
| full_seen_clr | input | 1 | Clears the sticky full flag |
| mb_pending | output | 1 | At least one entry stored (interrupt level) |
| mb_full | output | 1 | Queue holds DEPTH entries |
| mb_full_seen | output | 1 | Sticky record that the queue was full |

## Verification
The assertions watch on every cycle the relationships between the flags. Full implies pending, and full implies the sticky flag is set. The sticky flag holds unless cleared. An empty queue stays empty without a high-half write, and a full queue stays full through a dropped commit. A read of an empty queue or of a foreign address returns 0. What they cannot see is data: that the two halves are paired correctly, that the order is kept, that a dropped commit leaves contents intact, and that the holding register survives foreign writes and commits. These are shown only by the bench scenarios, which compare each popped entry against a model queue.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef logic [31:0] word_t;

    typedef struct packed {
        word_t hi;
        word_t lo;
    } entry_t;

    typedef struct packed {
        logic lo_wr;
        logic hi_wr;
        logic lo_rd;
        logic hi_rd;
    } access_t;

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode #(
    parameter int unsigned          ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]    LO_ADDR = 8'h10
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic                rd_en,
    output mbox_pkg::access_t   acc
);
    localparam logic [ADDR_W-1:0] HI_ADDR = LO_ADDR + ADDR_W'(4);

    logic hit_lo;
    logic hit_hi;

    always_comb begin
        hit_lo    = (addr == LO_ADDR);
        hit_hi    = (addr == HI_ADDR);
        acc.lo_wr = wr_en & hit_lo;
        acc.hi_wr = wr_en & hit_hi;
        acc.lo_rd = rd_en & hit_lo;
        acc.hi_rd = rd_en & hit_hi;
    end

endmodule

// File: rtl/mbox_stage.sv
module mbox_stage (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  mbox_pkg::word_t din,
    output mbox_pkg::word_t hold
);
    mbox_pkg::word_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load) hold_d = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign hold = hold_q;

endmodule

// File: rtl/mbox_ring.sv
module mbox_ring #(
    parameter int unsigned DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  mbox_pkg::entry_t push_data,
    input  logic             pop,
    input  logic             seen_clr,
    output mbox_pkg::entry_t head,
    output logic             not_empty,
    output logic             full,
    output logic             full_seen
);
    import mbox_pkg::*;

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic          seen;
    } ctl_t;

    ctl_t               ctl_d, ctl_q;
    entry_t [DEPTH-1:0] slot_d, slot_q;
    logic   [DEPTH-1:0] slot_we;

    logic empty_now, full_now, full_next;
    logic push_ok, pop_ok;

    always_comb begin
        empty_now = (ctl_q.wp == ctl_q.rp);
        full_now  = (ctl_q.wp[AW] != ctl_q.rp[AW]) &&
                    (ctl_q.wp[AW-1:0] == ctl_q.rp[AW-1:0]);
        push_ok   = push & ~full_now;
        pop_ok    = pop & ~empty_now;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_we
        assign slot_we[i] = push_ok && (ctl_q.wp[AW-1:0] == AW'(i));
    end

    always_comb begin
        ctl_d = ctl_q;
        if (push_ok) ctl_d.wp = ctl_q.wp + PW'(1);
        if (pop_ok)  ctl_d.rp = ctl_q.rp + PW'(1);
        full_next  = (ctl_d.wp[AW] != ctl_d.rp[AW]) &&
                     (ctl_d.wp[AW-1:0] == ctl_d.rp[AW-1:0]);
        ctl_d.seen = full_next | (ctl_q.seen & ~seen_clr);

        slot_d = slot_q;
        for (int k = 0; k < DEPTH; k++) begin
            if (slot_we[k]) slot_d[k] = push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            slot_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            slot_q <= slot_d;
        end
    end

    assign head      = slot_q[ctl_q.rp[AW-1:0]];
    assign not_empty = ~empty_now;
    assign full      = full_now;
    assign full_seen = ctl_q.seen;

endmodule

// File: rtl/mbox_fifo64.sv
module mbox_fifo64 #(
    parameter int unsigned          DEPTH   = 16,
    parameter int unsigned          ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]    LO_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic              rd_en,
    output logic [31:0]       rdata,
    input  logic              full_seen_clr,
    output logic              mb_pending,
    output logic              mb_full,
    output logic              mb_full_seen
);
    import mbox_pkg::*;

    access_t acc;
    word_t   hold;
    entry_t  head;
    entry_t  new_entry;

    mbox_decode #(.ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR)) u_dec (
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .acc   (acc)
    );

    mbox_stage u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (acc.lo_wr),
        .din   (wdata),
        .hold  (hold)
    );

    always_comb begin
        new_entry.hi = wdata;
        new_entry.lo = hold;
    end

    mbox_ring #(.DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (acc.hi_wr),
        .push_data (new_entry),
        .pop       (acc.hi_rd),
        .seen_clr  (full_seen_clr),
        .head      (head),
        .not_empty (mb_pending),
        .full      (mb_full),
        .full_seen (mb_full_seen)
    );

    always_comb begin
        rdata = '0;
        if (mb_pending) begin
            if (acc.lo_rd) rdata = head.lo;
            if (acc.hi_rd) rdata = head.hi;
        end
    end

endmodule

// File: rtl/mbox_fifo64_chk.sv
module mbox_fifo64_chk #(
    parameter int unsigned          ADDR_W  = 8,
    parameter logic [ADDR_W-1:0]    LO_ADDR = 8'h10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [31:0]       rdata,
    input logic              full_seen_clr,
    input logic              mb_pending,
    input logic              mb_full,
    input logic              mb_full_seen
);
    localparam logic [ADDR_W-1:0] HI_ADDR = LO_ADDR + ADDR_W'(4);

    logic hi_w, hi_r, lo_w, foreign;
    assign hi_w    = wr_en && (addr == HI_ADDR);
    assign hi_r    = rd_en && (addr == HI_ADDR);
    assign lo_w    = wr_en && (addr == LO_ADDR);
    assign foreign = (addr != LO_ADDR) && (addr != HI_ADDR);

    // R7
    full_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mb_full |-> mb_pending);

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_full && hi_w && !hi_r) |=> mb_full);

    // R8
    seen_tracks_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mb_full |-> mb_full_seen);

    // R8
    seen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_full_seen && !full_seen_clr) |=> mb_full_seen);

    // R9
    empty_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mb_pending && !hi_w) |=> !mb_pending);

    // R9
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mb_pending) |-> (rdata == 32'h0));

    // R2
    low_write_no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_w && !mb_pending) |=> !mb_pending);

    // R10
    foreign_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && foreign) |-> (rdata == 32'h0));

endmodule

bind mbox_fifo64 mbox_fifo64_chk #(.ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr          (addr),
    .wr_en         (wr_en),
    .rd_en         (rd_en),
    .rdata         (rdata),
    .full_seen_clr (full_seen_clr),
    .mb_pending    (mb_pending),
    .mb_full       (mb_full),
    .mb_full_seen  (mb_full_seen)
);

// File: tb/mbox_fifo64_tb.sv
module mbox_fifo64_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int ADDR_W     = 8;
    localparam logic [ADDR_W-1:0] LO = 8'h10;
    localparam logic [ADDR_W-1:0] HI = 8'h14;
    localparam logic [ADDR_W-1:0] OTHER = 8'h00;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr;
    logic              wr_en, rd_en, full_seen_clr;
    logic [31:0]       wdata, rdata;
    logic              mb_pending, mb_full, mb_full_seen;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    logic [63:0] exp_q[$];
    logic [31:0] hold_m;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_fifo64 #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .LO_ADDR(LO)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .full_seen_clr(full_seen_clr),
        .mb_pending(mb_pending), .mb_full(mb_full), .mb_full_seen(mb_full_seen)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic bus_read(logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        full_seen_clr = 1'b1;
        @(posedge clk); #1;
        full_seen_clr = 1'b0;
    endtask

    // driver: high-half commit, expected entry into the scoreboard
    task automatic push_hi(logic [31:0] hi);
        if (exp_q.size() < DEPTH) exp_q.push_back({hi, hold_m});
        bus_write(HI, hi);
    endtask

    task automatic push_entry(logic [31:0] lo, logic [31:0] hi);
        bus_write(LO, lo);
        hold_m = lo;
        push_hi(hi);
    endtask

    // monitor: pull one entry from the design and compare with the scoreboard
    task automatic pop_check(string req);
        logic [31:0] lo_a, lo_b, hi_a;
        logic [63:0] exp;
        exp = (exp_q.size() > 0) ? exp_q.pop_front() : 64'h0;
        bus_read(LO, lo_a);
        bus_read(LO, lo_b);
        bus_read(HI, hi_a);
        check({req, " R4 low half"}, {32'h0, lo_a}, {32'h0, exp[31:0]});
        check({req, " R4 low read keeps entry"}, {32'h0, lo_b}, {32'h0, exp[31:0]});
        check({req, " R5 high half"}, {32'h0, hi_a}, {32'h0, exp[63:32]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        rst_n = 1'b0; addr = '0; wr_en = 0; rd_en = 0; wdata = '0;
        full_seen_clr = 0; hold_m = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check("R1 pending", mb_pending, 0);
        check("R1 full", mb_full, 0);
        check("R1 full_seen", mb_full_seen, 0);

        // R2 low write alone adds nothing
        bus_write(LO, 32'hA5A5_0001);
        hold_m = 32'hA5A5_0001;
        check("R2 no entry after low write", mb_pending, 0);

        // R3 high write commits
        push_hi(32'h5A5A_0001);
        check("R3 pending after commit", mb_pending, 1);
        pop_check("R3");
        check("R5 empty after pop", mb_pending, 0);

        // R6 ordering
        push_entry(32'h1111_0000, 32'h1111_FFFF);
        push_entry(32'h2222_0000, 32'h2222_FFFF);
        push_entry(32'h3333_0000, 32'h3333_FFFF);
        for (int i = 0; i < 3; i++) pop_check("R6");
        check("R6 drained", mb_pending, 0);

        // R11 holding register reused
        bus_write(LO, 32'hCAFE_0000);
        hold_m = 32'hCAFE_0000;
        push_hi(32'h0000_0001);
        push_hi(32'h0000_0002);
        pop_check("R11");
        pop_check("R11");

        // R10 foreign write ignored, foreign read returns 0
        bus_write(OTHER, 32'hDEAD_BEEF);
        check("R10 foreign write no entry", mb_pending, 0);
        push_hi(32'h0000_0003);
        bus_read(OTHER, r);
        check("R10 foreign read zero", {32'h0, r}, 64'h0);
        pop_check("R10 holding untouched");

        // R7 fill, drop, R8 sticky
        for (int i = 0; i < DEPTH; i++) begin
            push_entry(32'h4000_0000 + i, 32'h8000_0000 + i);
            if (i < DEPTH - 1) check("R7 not full early", mb_full, 0);
        end
        check("R7 full", mb_full, 1);
        check("R8 seen with full", mb_full_seen, 1);
        push_entry(32'hBAD0_0000, 32'hBAD0_FFFF);
        check("R7 still full after drop", mb_full, 1);
        pulse_clr();
        check("R8 clear ignored while full", mb_full_seen, 1);
        for (int i = 0; i < DEPTH; i++) pop_check("R7 contents");
        check("R7 dropped entry absent", mb_pending, 0);
        check("R8 seen after drain", mb_full_seen, 1);
        pulse_clr();
        check("R8 cleared", mb_full_seen, 0);

        // R9 empty reads
        bus_read(HI, r);
        check("R9 empty high read zero", {32'h0, r}, 64'h0);
        bus_read(LO, r);
        check("R9 empty low read zero", {32'h0, r}, 64'h0);
        check("R9 still empty", mb_pending, 0);
        check("R9 full stays low", mb_full, 0);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule